// File: doc/BRIEF.md
# NAND Parameter Page Reader

This block brings a freshly attached NAND device up to the point where its geometry is known. A single `start` pulse makes it probe the device's identification area for the four-character compliance signature. When the signature is present, the block asks the device for its parameter page, waits on an external status-polling unit until the device reports ready, switches the device back to data output, and streams the first 116 page bytes in. While those bytes arrive it picks out the geometry fields at fixed byte positions, so no page-sized buffer is needed.

The device is reached through a single-outstanding byte bus. Each transfer is a command write, an address write or a data read, and the device side finishes it with `busAck`. The status wait is handed to a separate polling unit through a hold-until-done request. At the end of a run, `done` pulses together with a result code. The decoded fields are committed to the output registers only when a run succeeds, so a failed probe or a blank page leaves the previous geometry in place.

Top module: `onfi_param_reader`

## Requirements
- R1: After an accepted `start`, the first bus transfers are, in this order: a command write of 0x90, an address write of 0x20, then four data reads. `busKind` encodes a command write as 0, an address write as 1 and a data read as 2.
- R2: If the four probe bytes are not ASCII 'O','N','F','I' in that order, the run ends with `errCode` = 1 (no device). There is no further bus transfer and no poll request, and the field outputs keep their previous values.
- R3: After a matching signature, the block issues a command write of 0xEC and an address write of 0x00. It then holds `pollReq` until `pollDone`, issues a command write of 0x00, and performs exactly 116 data reads before finishing.
- R4: If all 116 page bytes read 0xFF, the run ends with `errCode` = 2 (blank page) and the field outputs keep their previous values.
- R5: On success (`errCode` = 0), the outputs take these values. Each multi-byte field is little-endian, with the lowest byte position as its least significant byte.
  - `mfrId` is page byte 64.
  - `busWide` is bit 0 of byte 6.
  - `modelByte` is byte 49.
  - `pageBytes` is bytes 80..83.
  - `spareBytes` is bytes 84..85.
  - `pagesPerBlock` is bytes 92..95.
  - `blocksPerLun` is bytes 96..99.
  - `lunCount` is byte 100.
  - `eccBits` is byte 112.
- R6: Field outputs change only in the cycle in which `done` is high with `errCode` = 0.
- R7: `done` is a one-cycle pulse. `errCode` reads 0 while a run is in progress, takes the run's result together with `done`, and holds it until the next accepted `start`. `errCode` never takes the value 3.
- R8: `busy` rises in the cycle after an accepted `start` and falls together with `done`. A `start` while `busy` is ignored. No bus or poll request is made while `busy` is low.
- R9: A bus request, once raised, stays raised with stable `busKind` and `busWrData` until `busAck`.
- R10: After reset, `busy`, `done`, `busReq`, `pollReq` and `errCode` are 0 and every field output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe and read run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| errCode | output | 2 | 0 success, 1 no device, 2 blank page |
| busReq | output | 1 | Byte bus transfer request |
| busKind | output | 2 | 0 command write, 1 address write, 2 data read |
| busWrData | output | 8 | Command or address byte |
| busAck | input | 1 | Transfer complete; read data valid this cycle |
| busRdData | input | 8 | Read byte from the device |
| pollReq | output | 1 | Request to the status-polling unit |
| pollDone | input | 1 | Polling unit reports the device ready |
| mfrId | output | 8 | Manufacturer identifier |
| busWide | output | 1 | Device data bus is 16 bits wide |
| modelByte | output | 8 | Model character |
| pageBytes | output | 32 | Data bytes per page |
| spareBytes | output | 16 | Spare bytes per page |
| pagesPerBlock | output | 32 | Pages per erase block |
| blocksPerLun | output | 32 | Blocks per logical unit |
| lunCount | output | 8 | Number of logical units |
| eccBits | output | 8 | Required ECC correction bits |

## Verification
The assertions assume that the device side raises `busAck` only while `busReq` is high and `pollDone` only while `pollReq` is high, each for a single cycle. The bench's device model meets this by deciding at every falling edge whether to answer the request it currently sees, and by dropping each answer at the next falling edge. The model stalls at random so that request hold times vary. It also serves signatures and page contents that are random, corrupted or blank, built independently of the design.

// File: rtl/onfi_pkg.sv
package onfi_pkg;

  localparam int PAGE_LEN = 116;
  localparam int CNT_W    = $clog2(PAGE_LEN + 1);
  localparam int SIG_LEN  = 4;

  localparam logic [7:0] CMD_PROBE   = 8'h90;
  localparam logic [7:0] ADDR_PROBE  = 8'h20;
  localparam logic [7:0] CMD_PARAM   = 8'hEC;
  localparam logic [7:0] ADDR_PARAM  = 8'h00;
  localparam logic [7:0] CMD_DATAOUT = 8'h00;
  localparam logic [7:0] BLANK_BYTE  = 8'hFF;

  // byte positions inside the parameter page
  localparam int OFS_BUSW  = 6;
  localparam int OFS_MODEL = 49;
  localparam int OFS_MFR   = 64;
  localparam int OFS_PAGE  = 80;
  localparam int OFS_SPARE = 84;
  localparam int OFS_PPB   = 92;
  localparam int OFS_BPL   = 96;
  localparam int OFS_LUNS  = 100;
  localparam int OFS_ECC   = 112;

  typedef enum logic [1:0] {
    BUS_CMD  = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_READ = 2'd2
  } busKind_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_NODEV = 2'd1,
    ERR_BLANK = 2'd2
  } errCode_e;

  typedef struct packed {
    logic clrCnt;    // restart byte counter and running flags
    logic sigByte;   // a signature byte is on busRdData
    logic pageByte;  // a page byte is on busRdData
    logic commit;    // copy captured fields to outputs
  } dpStrobe_t;

  function automatic logic [7:0] sigChar(input logic [1:0] idx);
    case (idx)
      2'd0:    sigChar = 8'h4F; // O
      2'd1:    sigChar = 8'h4E; // N
      2'd2:    sigChar = 8'h46; // F
      default: sigChar = 8'h49; // I
    endcase
  endfunction

endpackage

// File: rtl/onfi_field_grab.sv
module onfi_field_grab #(
  parameter int OFFSET = 0,
  parameter int NBYTES = 1,
  parameter int CNT_W  = 7,
  localparam int VAL_W = 8 * NBYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] byteIdx,
  input  logic [7:0]       rdData,
  input  logic             pageByte,
  input  logic             commit,
  output logic [VAL_W-1:0] value
);

  logic [VAL_W-1:0] shadow;

  // one byte lane per field byte, little-endian placement
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadow[8*b +: 8] <= '0;
      end else if (pageByte && byteIdx == CNT_W'(OFFSET + b)) begin
        shadow[8*b +: 8] <= rdData;
      end
    end
  end

  // the last lane can arrive in the same cycle as the commit
  logic [VAL_W-1:0] shadowNow;
  always_comb begin
    shadowNow = shadow;
    for (int b = 0; b < NBYTES; b++) begin
      if (pageByte && byteIdx == CNT_W'(OFFSET + b)) begin
        shadowNow[8*b +: 8] = rdData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value <= '0;
    end else if (commit) begin
      value <= shadowNow;
    end
  end

endmodule

// File: rtl/onfi_ctrl.sv
module onfi_ctrl
  import onfi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             busAck,
  input  logic             pollDone,
  input  logic [CNT_W-1:0] byteIdx,
  input  logic             sigOkNext,
  input  logic             blankNext,
  output dpStrobe_t        strobe,
  output logic             busReq,
  output logic [1:0]       busKind,
  output logic [7:0]       busWrData,
  output logic             pollReq,
  output logic             busy,
  output logic             done,
  output logic [1:0]       errCode
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ID_CMD, ST_ID_ADDR, ST_ID_READ,
    ST_PG_CMD, ST_PG_ADDR, ST_PG_POLL, ST_PG_REOPEN, ST_PG_READ
  } state_e;

  state_e   state, stateNext;
  logic     finish;
  errCode_e finishCode;
  logic     startAcc;

  assign startAcc = start && (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    busReq     = 1'b0;
    busKind    = BUS_CMD;
    busWrData  = 8'h00;
    pollReq    = 1'b0;
    finish     = 1'b0;
    finishCode = ERR_NONE;
    case (state)
      ST_IDLE: begin
        if (start) stateNext = ST_ID_CMD;
      end
      ST_ID_CMD: begin
        busReq    = 1'b1;
        busWrData = CMD_PROBE;
        if (busAck) stateNext = ST_ID_ADDR;
      end
      ST_ID_ADDR: begin
        busReq    = 1'b1;
        busKind   = BUS_ADDR;
        busWrData = ADDR_PROBE;
        if (busAck) begin
          strobe.clrCnt = 1'b1;
          stateNext     = ST_ID_READ;
        end
      end
      ST_ID_READ: begin
        busReq  = 1'b1;
        busKind = BUS_READ;
        if (busAck) begin
          strobe.sigByte = 1'b1;
          if (byteIdx == CNT_W'(SIG_LEN - 1)) begin
            if (sigOkNext) begin
              stateNext = ST_PG_CMD;
            end else begin
              finish     = 1'b1;
              finishCode = ERR_NODEV;
              stateNext  = ST_IDLE;
            end
          end
        end
      end
      ST_PG_CMD: begin
        busReq    = 1'b1;
        busWrData = CMD_PARAM;
        if (busAck) stateNext = ST_PG_ADDR;
      end
      ST_PG_ADDR: begin
        busReq    = 1'b1;
        busKind   = BUS_ADDR;
        busWrData = ADDR_PARAM;
        if (busAck) stateNext = ST_PG_POLL;
      end
      ST_PG_POLL: begin
        pollReq = 1'b1;
        if (pollDone) stateNext = ST_PG_REOPEN;
      end
      ST_PG_REOPEN: begin
        busReq    = 1'b1;
        busWrData = CMD_DATAOUT;
        if (busAck) begin
          strobe.clrCnt = 1'b1;
          stateNext     = ST_PG_READ;
        end
      end
      ST_PG_READ: begin
        busReq  = 1'b1;
        busKind = BUS_READ;
        if (busAck) begin
          strobe.pageByte = 1'b1;
          if (byteIdx == CNT_W'(PAGE_LEN - 1)) begin
            finish    = 1'b1;
            stateNext = ST_IDLE;
            if (blankNext) begin
              finishCode = ERR_BLANK;
            end else begin
              finishCode    = ERR_NONE;
              strobe.commit = 1'b1;
            end
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      state <= stateNext;
      done  <= finish;
      if (startAcc)    errCode <= ERR_NONE;
      else if (finish) errCode <= finishCode;
    end
  end

endmodule

// File: rtl/onfi_dp.sv
module onfi_dp
  import onfi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [7:0]       rdData,
  output logic [CNT_W-1:0] byteIdx,
  output logic             sigOkNext,
  output logic             blankNext,
  output logic [7:0]       mfrId,
  output logic             busWide,
  output logic [7:0]       modelByte,
  output logic [31:0]      pageBytes,
  output logic [15:0]      spareBytes,
  output logic [31:0]      pagesPerBlock,
  output logic [31:0]      blocksPerLun,
  output logic [7:0]       lunCount,
  output logic [7:0]       eccBits
);

  logic sigMatch;
  logic allBlank;
  logic byteStrobe;

  assign byteStrobe = strobe.sigByte || strobe.pageByte;
  assign sigOkNext  = sigMatch && (rdData == sigChar(byteIdx[1:0]));
  assign blankNext  = allBlank && (rdData == BLANK_BYTE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteIdx  <= '0;
      sigMatch <= 1'b1;
      allBlank <= 1'b1;
    end else if (strobe.clrCnt) begin
      byteIdx  <= '0;
      sigMatch <= 1'b1;
      allBlank <= 1'b1;
    end else if (byteStrobe) begin
      byteIdx <= byteIdx + 1'b1;
      if (strobe.sigByte)  sigMatch <= sigOkNext;
      if (strobe.pageByte) allBlank <= blankNext;
    end
  end

  logic [7:0] busWideByte;
  assign busWide = busWideByte[0];

  onfi_field_grab #(.OFFSET(OFS_BUSW), .NBYTES(1), .CNT_W(CNT_W)) i_grabBusw (
    .clk, .rstN, .byteIdx, .rdData, .pageByte(strobe.pageByte),
    .commit(strobe.commit), .value(busWideByte));
  onfi_field_grab #(.OFFSET(OFS_MODEL), .NBYTES(1), .CNT_W(CNT_W)) i_grabModel (
    .clk, .rstN, .byteIdx, .rdData, .pageByte(strobe.pageByte),
    .commit(strobe.commit), .value(modelByte));
  onfi_field_grab #(.OFFSET(OFS_MFR), .NBYTES(1), .CNT_W(CNT_W)) i_grabMfr (
    .clk, .rstN, .byteIdx, .rdData, .pageByte(strobe.pageByte),
    .commit(strobe.commit), .value(mfrId));
  onfi_field_grab #(.OFFSET(OFS_PAGE), .NBYTES(4), .CNT_W(CNT_W)) i_grabPage (
    .clk, .rstN, .byteIdx, .rdData, .pageByte(strobe.pageByte),
    .commit(strobe.commit), .value(pageBytes));
  onfi_field_grab #(.OFFSET(OFS_SPARE), .NBYTES(2), .CNT_W(CNT_W)) i_grabSpare (
    .clk, .rstN, .byteIdx, .rdData, .pageByte(strobe.pageByte),
    .commit(strobe.commit), .value(spareBytes));
  onfi_field_grab #(.OFFSET(OFS_PPB), .NBYTES(4), .CNT_W(CNT_W)) i_grabPpb (
    .clk, .rstN, .byteIdx, .rdData, .pageByte(strobe.pageByte),
    .commit(strobe.commit), .value(pagesPerBlock));
  onfi_field_grab #(.OFFSET(OFS_BPL), .NBYTES(4), .CNT_W(CNT_W)) i_grabBpl (
    .clk, .rstN, .byteIdx, .rdData, .pageByte(strobe.pageByte),
    .commit(strobe.commit), .value(blocksPerLun));
  onfi_field_grab #(.OFFSET(OFS_LUNS), .NBYTES(1), .CNT_W(CNT_W)) i_grabLuns (
    .clk, .rstN, .byteIdx, .rdData, .pageByte(strobe.pageByte),
    .commit(strobe.commit), .value(lunCount));
  onfi_field_grab #(.OFFSET(OFS_ECC), .NBYTES(1), .CNT_W(CNT_W)) i_grabEcc (
    .clk, .rstN, .byteIdx, .rdData, .pageByte(strobe.pageByte),
    .commit(strobe.commit), .value(eccBits));

endmodule

// File: rtl/onfi_param_reader.sv
module onfi_param_reader
  import onfi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic [1:0]  errCode,
  output logic        busReq,
  output logic [1:0]  busKind,
  output logic [7:0]  busWrData,
  input  logic        busAck,
  input  logic [7:0]  busRdData,
  output logic        pollReq,
  input  logic        pollDone,
  output logic [7:0]  mfrId,
  output logic        busWide,
  output logic [7:0]  modelByte,
  output logic [31:0] pageBytes,
  output logic [15:0] spareBytes,
  output logic [31:0] pagesPerBlock,
  output logic [31:0] blocksPerLun,
  output logic [7:0]  lunCount,
  output logic [7:0]  eccBits
);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] byteIdx;
  logic             sigOkNext;
  logic             blankNext;

  onfi_ctrl i_ctrl (
    .clk, .rstN, .start, .busAck, .pollDone, .byteIdx, .sigOkNext, .blankNext,
    .strobe, .busReq, .busKind, .busWrData, .pollReq, .busy, .done, .errCode);

  onfi_dp i_dp (
    .clk, .rstN, .strobe, .rdData(busRdData), .byteIdx, .sigOkNext, .blankNext,
    .mfrId, .busWide, .modelByte, .pageBytes, .spareBytes, .pagesPerBlock,
    .blocksPerLun, .lunCount, .eccBits);

endmodule

// File: rtl/onfi_param_reader_chk.sv
module onfi_param_reader_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [1:0]  errCode,
  input logic        busReq,
  input logic [1:0]  busKind,
  input logic [7:0]  busWrData,
  input logic        busAck,
  input logic        pollReq,
  input logic        pollDone,
  input logic [31:0] pageBytes,
  input logic [31:0] pagesPerBlock,
  input logic [7:0]  mfrId
);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busKind) && $stable(busWrData));

  p_poll_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    pollReq && !pollDone |=> pollReq);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_err_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> errCode == 2'd0);

  p_err_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    errCode != 2'd3);

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !done && !$past(start) |-> $stable(errCode));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq && !pollReq);

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  p_fields_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(done && errCode == 2'd0) |->
      $stable(pageBytes) && $stable(pagesPerBlock) && $stable(mfrId));

endmodule

bind onfi_param_reader onfi_param_reader_chk i_chk (.*);

// File: tb/test_onfi_param_reader.sv
`timescale 1ns/1ps
module test_onfi_param_reader;

  localparam int PLEN = 116;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [1:0]  errCode;
  logic        busReq;
  logic [1:0]  busKind;
  logic [7:0]  busWrData;
  logic        busAck = 1'b0;
  logic [7:0]  busRdData = 8'h00;
  logic        pollReq;
  logic        pollDone = 1'b0;
  logic [7:0]  mfrId, modelByte, lunCount, eccBits;
  logic        busWide;
  logic [31:0] pageBytes, pagesPerBlock, blocksPerLun;
  logic [15:0] spareBytes;

  always #2 clk = ~clk;

  onfi_param_reader i_onfi_param_reader (.*);

  // device model content
  logic [7:0] sigMem [4];
  logic [7:0] pageMem [PLEN];
  int         mode = 0;
  int         rdIdx = 0;
  // transaction log: kind 0 cmd, 1 addr, 2 read, 3 poll
  int         logKind [256];
  logic [7:0] logData [256];
  int         logN = 0;

  int nChecks = 0;
  int nFail = 0;

  // expected fields
  logic [7:0]  eMfr = 0, eModel = 0, eLuns = 0, eEcc = 0;
  logic        eBusw = 0;
  logic [31:0] ePage = 0, ePpb = 0, eBpl = 0;
  logic [15:0] eSpare = 0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] le(input int off, input int n);
    logic [31:0] v = 0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = pageMem[off + i];
    return v;
  endfunction

  // device side: answers requests at falling edges, random stalls
  initial begin
    forever begin
      @(negedge clk);
      busAck   = 1'b0;
      pollDone = 1'b0;
      if (rstN && busReq && ($urandom % 4 != 0)) begin
        busAck = 1'b1;
        if (logN < 256) begin
          logKind[logN] = int'(busKind);
          logData[logN] = (busKind == 2'd2) ? 8'h00 : busWrData;
          logN++;
        end
        if (busKind == 2'd0) begin
          rdIdx = 0;
          if (busWrData == 8'h90) mode = 1;
          else if (busWrData == 8'h00) mode = 2;
          else mode = 0;
        end else if (busKind == 2'd2) begin
          if (mode == 1 && rdIdx < 4) busRdData = sigMem[rdIdx];
          else if (mode == 2 && rdIdx < PLEN) busRdData = pageMem[rdIdx];
          else busRdData = 8'h00;
          rdIdx++;
        end
      end else if (rstN && pollReq && ($urandom % 3 == 0)) begin
        pollDone = 1'b1;
        if (logN < 256) begin
          logKind[logN] = 3;
          logData[logN] = 8'h00;
          logN++;
        end
      end
    end
  end

  // pageKind: 0 random, 1 all blank, 2 blank but last byte
  task automatic fill(input logic sigGood, input int pageKind);
    sigMem[0] = 8'h4F; sigMem[1] = 8'h4E; sigMem[2] = 8'h46; sigMem[3] = 8'h49;
    if (!sigGood) begin
      int k = $urandom % 4;
      sigMem[k] = sigMem[k] ^ (8'h01 << ($urandom % 8));
    end
    for (int i = 0; i < PLEN; i++) begin
      if (pageKind == 0) pageMem[i] = 8'($urandom);
      else pageMem[i] = 8'hFF;
    end
    if (pageKind == 2) pageMem[PLEN-1] = 8'hFE;
  endtask

  task automatic runOnce(input logic sigGood, input int pageKind, input logic pokeStart);
    int  wd = 0;
    int  expN;
    int  expErr;
    logic seqOk;
    fill(sigGood, pageKind);
    logN = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", 64'(busy), 64'd1);
    chk(errCode == 2'd0, "R7 errCode cleared by start", 64'(errCode), 64'd0);
    while (!done && wd < 5000) begin
      if (pokeStart && wd == 20) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      wd++;
    end
    start = 1'b0;
    if (wd >= 5000) begin
      chk(1'b0, "R8 watchdog", 64'(wd), 64'd0);
      return;
    end
    chk(busy == 1'b0, "R8 busy falls with done", 64'(busy), 64'd0);
    // expected result
    if (!sigGood) expErr = 1;
    else if (pageKind == 1) expErr = 2;
    else expErr = 0;
    if (!sigGood) chk(errCode == 2'd1, "R2 no-device code", 64'(errCode), 64'd1);
    else if (pageKind == 1) chk(errCode == 2'd2, "R4 blank code", 64'(errCode), 64'd2);
    else chk(errCode == 2'd0, "R3 success code", 64'(errCode), 64'd0);
    // R1 probe sequence
    seqOk = (logN >= 6) && logKind[0] == 0 && logData[0] == 8'h90 &&
            logKind[1] == 1 && logData[1] == 8'h20;
    for (int i = 2; i < 6; i++) if (logN >= 6 && logKind[i] != 2) seqOk = 1'b0;
    chk(seqOk, "R1 probe sequence", 64'(logN), 64'd6);
    // R2/R3 remainder of sequence
    expN = sigGood ? 126 : 6;
    if (!sigGood) begin
      chk(logN == expN, "R2 nothing after bad signature", 64'(logN), 64'(expN));
    end else begin
      seqOk = (logN == expN) && logKind[6] == 0 && logData[6] == 8'hEC &&
              logKind[7] == 1 && logData[7] == 8'h00 && logKind[8] == 3 &&
              logKind[9] == 0 && logData[9] == 8'h00;
      for (int i = 10; i < 126; i++) if (logN == expN && logKind[i] != 2) seqOk = 1'b0;
      chk(seqOk, "R3 page read sequence", 64'(logN), 64'(expN));
    end
    if (expErr == 0) begin
      eMfr = pageMem[64]; eBusw = pageMem[6][0]; eModel = pageMem[49];
      ePage = le(80, 4); eSpare = 16'(le(84, 2)); ePpb = le(92, 4);
      eBpl = le(96, 4); eLuns = pageMem[100]; eEcc = pageMem[112];
    end
    begin
      string tag = (expErr == 0) ? "R5" : (expErr == 1 ? "R2 unchanged" : "R4 unchanged");
      chk(mfrId == eMfr, {tag, " mfrId"}, 64'(mfrId), 64'(eMfr));
      chk(busWide == eBusw, {tag, " busWide"}, 64'(busWide), 64'(eBusw));
      chk(modelByte == eModel, {tag, " modelByte"}, 64'(modelByte), 64'(eModel));
      chk(pageBytes == ePage, {tag, " pageBytes"}, 64'(pageBytes), 64'(ePage));
      chk(spareBytes == eSpare, {tag, " spareBytes"}, 64'(spareBytes), 64'(eSpare));
      chk(pagesPerBlock == ePpb, {tag, " pagesPerBlock"}, 64'(pagesPerBlock), 64'(ePpb));
      chk(blocksPerLun == eBpl, {tag, " blocksPerLun"}, 64'(blocksPerLun), 64'(eBpl));
      chk(lunCount == eLuns, {tag, " lunCount"}, 64'(lunCount), 64'(eLuns));
      chk(eccBits == eEcc, {tag, " eccBits"}, 64'(eccBits), 64'(eEcc));
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 done single pulse", 64'(done), 64'd0);
    chk(errCode == 2'(expErr), "R7 errCode held", 64'(errCode), 64'(expErr));
    // R6 fields stay put while idle
    repeat (3) @(negedge clk);
    chk(pageBytes == ePage && mfrId == eMfr, "R6 fields stable idle",
        64'(pageBytes), 64'(ePage));
    chk(busReq == 1'b0 && pollReq == 1'b0, "R8 quiet when idle",
        64'({busReq, pollReq}), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(busy == 0 && done == 0 && busReq == 0 && pollReq == 0, "R10 control idle",
        64'({busy, done, busReq, pollReq}), 64'd0);
    chk(errCode == 2'd0, "R10 errCode", 64'(errCode), 64'd0);
    chk(pageBytes == 0 && mfrId == 0 && eccBits == 0 && spareBytes == 0,
        "R10 fields zero", 64'(pageBytes), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    runOnce(1'b1, 0, 1'b0);  // R5 success
    runOnce(1'b0, 0, 1'b0);  // R2 bad signature
    runOnce(1'b1, 1, 1'b0);  // R4 blank page
    runOnce(1'b1, 2, 1'b0);  // R4 almost blank counts as data
    runOnce(1'b1, 0, 1'b1);  // R8 start while busy ignored
    runOnce(1'b1, 1, 1'b0);  // R6 blank after success keeps fields
    // random mix
    for (int n = 0; n < 30; n++) begin
      int r = $urandom % 8;
      runOnce(r != 0, (r == 1) ? 1 : 0, ($urandom % 4) == 0);
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule